// File: doc/BRIEF.md
# Lockable Clock Control Register

This block is one software-visible clock control word with protection built in. Software programs these fields through it:
- the clock-output and bus drive mode;
- a multiplication factor and a pre-divider for the frequency synthesizer;
- a low-power-mode field and a clock-source select;
- a request to move onto the backup clock.

Two protection bits take only the first write after power-on. The frequency lock freezes the synthesizer fields. The power lock freezes the power fields. The power lock also turns bad behaviour into a one-cycle hard-reset request: a change to the synthesizer fields raises it, and so does an operating mode other than normal-high.

The block also watches the PLL lock signal while the chip is in hard reset. Limp mode is enabled through an input. If limp mode is enabled and loss-of-lock switching is allowed, losing lock requests a switch to the backup clock. If loss-of-lock switching is disabled, the block instead keeps hard reset held until lock returns. Power-on reset is asynchronous and active low, and its release is synchronized to the clock. The flag that remembers the first write is cleared only by power-on reset.

Top module: `ccr_lockreg`

## Requirements

Register layout:

| Bits | Field |
|------|-------|
| [1:0] | output mode |
| [2] | loss-of-lock switch disable |
| [3] | frequency lock |
| [4] | power lock |
| [5] | backup switch |
| [6] | clock source |
| [9:8] | low-power mode |
| [19:12] | multiplication factor |
| [23:20] | pre-divider |

Bits 7, 11:10 and 31:24 are reserved.

- R1: After power-on reset every field reads zero. The reserved bits always read zero, whatever is written to them.
- R2: The output mode field is decoded onto two outputs. 00 gives clock output on with full drive. 01 gives output on with half drive. 10 gives output off with full drive. 11 gives output off with half drive. `clko_en` is high for 00 and 01, and `drive_half` is high for 01 and 11.
- R3: Bits 3 and 4 take their value only from the first write after power-on reset. Later writes leave them unchanged.
- R4: While bit 3 is 1, writes leave the multiplication factor and the pre-divider unchanged.
- R5: While bit 4 is 1, writes leave the low-power mode and the clock source unchanged.
- R6: While bit 4 is 1, a write that changes the multiplication factor or the pre-divider pulses `hrst_req` in the cycle after the write. A write that leaves both fields the same gives no pulse.
- R7: While bit 4 is 1, `pmode` becoming non-zero pulses `hrst_req` once. Code 0 is normal-high.
- R8: A write of 1 to bit 5 while bit 5 is 0 and `limp_en` is 1 sets the bit and pulses both `bkup_req` and `hrst_req`. With `limp_en` at 0 the bit stays 0 and no pulse occurs.
- R9: With bit 2 at 0, `limp_en` at 1 and `hrst_active` at 1, a fall of `pll_locked` pulses `bkup_req` once.
- R10: With bit 2 at 1, losing lock gives no `bkup_req`. `hrst_hold` is high one cycle after any cycle with `hrst_active` high and `pll_locked` low, and low otherwise.
- R11: `hrst_req` is never high in two consecutive cycles.
- R12: A new power-on reset re-arms the first-write capture of bits 3 and 4.

## Ports

| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current register value |
| limp_en | input | 1 | Limp mode enabled |
| pll_locked | input | 1 | PLL lock indication, synchronous |
| hrst_active | input | 1 | Hard reset in progress |
| pmode | input | 3 | Current operating mode, 0 is normal-high |
| clko_en | output | 1 | Clock output enabled |
| drive_half | output | 1 | Reduced drive strength |
| mf | output | 8 | Multiplication factor |
| pdiv | output | 4 | Pre-divider |
| lpm | output | 2 | Low-power mode field |
| csrc | output | 1 | Clock source select |
| hrst_req | output | 1 | Hard-reset request pulse |
| bkup_req | output | 1 | Backup-clock switch request pulse |
| hrst_hold | output | 1 | Hold hard reset until lock returns |

## Verification

Every field is read back through `rd_data` right after the write edge. A wrong write-once flag therefore shows up at the next write: a lock bit changes when it should not, or a locked field moves.

A wrong pulse generator shows up one cycle after its cause, as a missing pulse, an extra pulse or a stretched pulse on `hrst_req` or `bkup_req`. A stale copy of the PLL lock signal shows up as a backup request on the wrong cycle, or as no request at all.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  // Fixed bit positions of the single-bit control fields.
  localparam int COM_LSB  = 0;
  localparam int LOLD_BIT = 2;
  localparam int FLK_BIT  = 3;
  localparam int PLK_BIT  = 4;
  localparam int BKS_BIT  = 5;
  localparam int CSRC_BIT = 6;
  localparam int LPM_LSB  = 8;

  typedef struct packed {
    logic [1:0] com;
    logic       lol_nosw;
    logic       frq_lock;
    logic       pm_lock;
    logic       bk_sw;
    logic       csrc;
  } ctl_t;
endpackage

// File: rtl/ccr_rst_sync.sv
module ccr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/ccr_regfile.sv
module ccr_regfile
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LPM_W  = 2,
  parameter int MF_W   = 8,
  parameter int PD_W   = 4,
  parameter int MF_LSB = 12,
  parameter int PD_LSB = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              limp_en,
  output ctl_t              ctl_q,
  output logic [LPM_W-1:0]  lpm_q,
  output logic [MF_W-1:0]   mf_q,
  output logic [PD_W-1:0]   pd_q,
  output logic              tamper,
  output logic              bk_set,
  output logic [DATA_W-1:0] rd_data
);
  ctl_t             ctl_d;
  logic [LPM_W-1:0] lpm_d;
  logic [MF_W-1:0]  mf_d;
  logic [PD_W-1:0]  pd_d;
  logic             once_q, once_d;

  // Next-state logic: the lock values before this write gate the fields.
  always_comb begin
    ctl_d  = ctl_q;
    lpm_d  = lpm_q;
    mf_d   = mf_q;
    pd_d   = pd_q;
    once_d = once_q;
    if (wr_en) begin
      ctl_d.com      = wr_data[COM_LSB +: 2];
      ctl_d.lol_nosw = wr_data[LOLD_BIT];
      if (!once_q) begin
        ctl_d.frq_lock = wr_data[FLK_BIT];
        ctl_d.pm_lock  = wr_data[PLK_BIT];
        once_d         = 1'b1;
      end
      if (!ctl_q.pm_lock) begin
        lpm_d      = wr_data[LPM_LSB +: LPM_W];
        ctl_d.csrc = wr_data[CSRC_BIT];
      end
      if (!ctl_q.frq_lock) begin
        mf_d = wr_data[MF_LSB +: MF_W];
        pd_d = wr_data[PD_LSB +: PD_W];
      end
      if (!wr_data[BKS_BIT])  ctl_d.bk_sw = 1'b0;
      else if (limp_en)       ctl_d.bk_sw = 1'b1;
    end
  end

  assign tamper = wr_en && ctl_q.pm_lock && ((mf_d != mf_q) || (pd_d != pd_q));
  assign bk_set = wr_en && wr_data[BKS_BIT] && limp_en && !ctl_q.bk_sw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      lpm_q  <= '0;
      mf_q   <= '0;
      pd_q   <= '0;
      once_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_d;
      lpm_q  <= lpm_d;
      mf_q   <= mf_d;
      pd_q   <= pd_d;
      once_q <= once_d;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[COM_LSB +: 2]         = ctl_q.com;
    rd_data[LOLD_BIT]             = ctl_q.lol_nosw;
    rd_data[FLK_BIT]              = ctl_q.frq_lock;
    rd_data[PLK_BIT]              = ctl_q.pm_lock;
    rd_data[BKS_BIT]              = ctl_q.bk_sw;
    rd_data[CSRC_BIT]             = ctl_q.csrc;
    rd_data[LPM_LSB +: LPM_W]     = lpm_q;
    rd_data[MF_LSB +: MF_W]       = mf_q;
    rd_data[PD_LSB +: PD_W]       = pd_q;
  end
endmodule

// File: rtl/ccr_guard.sv
module ccr_guard #(
  parameter int PM_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pm_lock,
  input  logic            lol_nosw,
  input  logic            limp_en,
  input  logic            hrst_active,
  input  logic            pll_locked,
  input  logic [PM_W-1:0] pmode,
  input  logic            tamper,
  input  logic            bk_set,
  output logic            hrst_req,
  output logic            bkup_req,
  output logic            hrst_hold
);
  logic viol, viol_q;
  logic pll_q;
  logic lol_fall;
  logic hr_q, hr_d;
  logic bk_q, bk_d;
  logic hold_q, hold_d;

  assign viol     = pm_lock && (pmode != '0);
  assign lol_fall = pll_q && !pll_locked && hrst_active && limp_en && !lol_nosw;

  always_comb begin
    hr_d   = (tamper || bk_set || (viol && !viol_q)) && !hr_q;
    bk_d   = (bk_set || lol_fall) && !bk_q;
    hold_d = hrst_active && lol_nosw && !pll_locked;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
      pll_q  <= 1'b0;
      hr_q   <= 1'b0;
      bk_q   <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      viol_q <= viol;
      pll_q  <= pll_locked;
      hr_q   <= hr_d;
      bk_q   <= bk_d;
      hold_q <= hold_d;
    end
  end

  assign hrst_req  = hr_q;
  assign bkup_req  = bk_q;
  assign hrst_hold = hold_q;
endmodule

// File: rtl/ccr_clkout.sv
module ccr_clkout (
  input  logic [1:0] com,
  output logic       clko_en,
  output logic       drive_half
);
  always_comb begin
    clko_en    = !com[1];
    drive_half = com[0];
  end
endmodule

// File: rtl/ccr_lockreg.sv
module ccr_lockreg
  import ccr_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int MF_W     = 8,
  parameter int PD_W     = 4,
  parameter int LPM_W    = 2,
  parameter int PM_W     = 3,
  parameter int SYNC_STG = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              limp_en,
  input  logic              pll_locked,
  input  logic              hrst_active,
  input  logic [PM_W-1:0]   pmode,
  output logic              clko_en,
  output logic              drive_half,
  output logic [MF_W-1:0]   mf,
  output logic [PD_W-1:0]   pdiv,
  output logic [LPM_W-1:0]  lpm,
  output logic              csrc,
  output logic              hrst_req,
  output logic              bkup_req,
  output logic              hrst_hold
);
  localparam int MF_LSB = LPM_LSB + LPM_W + 2;
  localparam int PD_LSB = MF_LSB + MF_W;

  logic rst_s_n;
  ctl_t ctl_q;
  logic tamper, bk_set;

  ccr_rst_sync #(.STAGES(SYNC_STG)) u_rsync (
    .clk    (clk),
    .arst_n (por_n),
    .rst_n  (rst_s_n)
  );

  ccr_regfile #(
    .DATA_W (DATA_W), .LPM_W (LPM_W), .MF_W (MF_W), .PD_W (PD_W),
    .MF_LSB (MF_LSB), .PD_LSB (PD_LSB)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .limp_en (limp_en),
    .ctl_q   (ctl_q),
    .lpm_q   (lpm),
    .mf_q    (mf),
    .pd_q    (pdiv),
    .tamper  (tamper),
    .bk_set  (bk_set),
    .rd_data (rd_data)
  );

  ccr_guard #(.PM_W(PM_W)) u_guard (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .pm_lock     (ctl_q.pm_lock),
    .lol_nosw    (ctl_q.lol_nosw),
    .limp_en     (limp_en),
    .hrst_active (hrst_active),
    .pll_locked  (pll_locked),
    .pmode       (pmode),
    .tamper      (tamper),
    .bk_set      (bk_set),
    .hrst_req    (hrst_req),
    .bkup_req    (bkup_req),
    .hrst_hold   (hrst_hold)
  );

  ccr_clkout u_cko (
    .com        (ctl_q.com),
    .clko_en    (clko_en),
    .drive_half (drive_half)
  );

  assign csrc = ctl_q.csrc;
endmodule

// File: rtl/ccr_lockreg_chk.sv
module ccr_lockreg_chk
  import ccr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int MF_W   = 8,
  parameter int PD_W   = 4,
  parameter int LPM_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] rd_data,
  input logic [MF_W-1:0]   mf,
  input logic [PD_W-1:0]   pdiv,
  input logic [LPM_W-1:0]  lpm,
  input logic              csrc,
  input logic              limp_en,
  input logic              hrst_req,
  input logic              bkup_req,
  input logic              hrst_hold
);
  p_flk_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FLK_BIT] |=> rd_data[FLK_BIT]);

  p_plk_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PLK_BIT] |=> rd_data[PLK_BIT]);

  p_freq_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[FLK_BIT] |=> ($stable(mf) && $stable(pdiv)));

  p_pwr_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[PLK_BIT] |=> ($stable(lpm) && $stable(csrc)));

  p_no_backup_without_limp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !limp_en |=> !bkup_req);

  p_hold_needs_disable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_hold |-> $past(rd_data[LOLD_BIT]));

  p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    hrst_req |=> !hrst_req);
endmodule

bind ccr_lockreg ccr_lockreg_chk #(
  .DATA_W (DATA_W), .MF_W (MF_W), .PD_W (PD_W), .LPM_W (LPM_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_s_n),
  .rd_data   (rd_data),
  .mf        (mf),
  .pdiv      (pdiv),
  .lpm       (lpm),
  .csrc      (csrc),
  .limp_en   (limp_en),
  .hrst_req  (hrst_req),
  .bkup_req  (bkup_req),
  .hrst_hold (hrst_hold)
);

// File: tb/sim_ccr_lockreg.sv
module sim_ccr_lockreg;
  logic        clk;
  logic        por_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        limp_en, pll_locked, hrst_active;
  logic [2:0]  pmode;
  logic        clko_en, drive_half;
  logic [7:0]  mf;
  logic [3:0]  pdiv;
  logic [1:0]  lpm;
  logic        csrc, hrst_req, bkup_req, hrst_hold;

  int total = 0;
  int bad   = 0;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic        hr;
    logic        bk;
    logic        hd;
  } item_t;
  item_t q[$];

  // Bench model of the register, driven by the requirements.
  logic [1:0] m_com, m_lpm;
  logic       m_lol, m_flk, m_plk, m_bks, m_csrc, m_once;
  logic [7:0] m_mf;
  logic [3:0] m_pd;

  ccr_lockreg u0 (
    .clk (clk), .por_n (por_n), .wr_en (wr_en), .wr_data (wr_data),
    .rd_data (rd_data), .limp_en (limp_en), .pll_locked (pll_locked),
    .hrst_active (hrst_active), .pmode (pmode), .clko_en (clko_en),
    .drive_half (drive_half), .mf (mf), .pdiv (pdiv), .lpm (lpm),
    .csrc (csrc), .hrst_req (hrst_req), .bkup_req (bkup_req),
    .hrst_hold (hrst_hold)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] enc();
    return {8'h00, m_pd, m_mf, 2'b00, m_lpm, 1'b0, m_csrc, m_bks, m_plk,
            m_flk, m_lol, m_com};
  endfunction

  task automatic cmp(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expected item per cycle, 3 ns after the edge.
  always @(posedge clk) begin
    #3;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      cmp(it.tag, "rd_data", rd_data, it.rd);
      cmp(it.tag, "mf", {24'h0, mf}, {24'h0, it.rd[19:12]});
      cmp(it.tag, "pdiv", {28'h0, pdiv}, {28'h0, it.rd[23:20]});
      cmp(it.tag, "lpm/csrc", {29'h0, lpm, csrc}, {29'h0, it.rd[9:8], it.rd[6]});
      cmp({it.tag, " R2"}, "clko_en", {31'h0, clko_en}, {31'h0, !it.rd[1]});
      cmp({it.tag, " R2"}, "drive_half", {31'h0, drive_half}, {31'h0, it.rd[0]});
      cmp(it.tag, "hrst_req", {31'h0, hrst_req}, {31'h0, it.hr});
      cmp(it.tag, "bkup_req", {31'h0, bkup_req}, {31'h0, it.bk});
      cmp(it.tag, "hrst_hold", {31'h0, hrst_hold}, {31'h0, it.hd});
    end
  end

  task automatic step(string tag, logic hr, logic bk, logic hd);
    item_t it;
    it.tag = tag; it.rd = enc(); it.hr = hr; it.bk = bk; it.hd = hd;
    q.push_back(it);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic model_clear();
    m_com = 0; m_lpm = 0; m_lol = 0; m_flk = 0; m_plk = 0;
    m_bks = 0; m_csrc = 0; m_once = 0; m_mf = 0; m_pd = 0;
  endtask

  task automatic por();
    por_n = 1'b0;
    model_clear();
    step("R1 reset held", 0, 0, 0);
    step("R12 reset held", 0, 0, 0);
    por_n = 1'b1;
    step("R1 release", 0, 0, 0);
    step("R1 release", 0, 0, 0);
    step("R1 release", 0, 0, 0);
  endtask

  task automatic wreg(string tag, logic [1:0] com, logic lol, logic flk, logic plk,
                      logic bks, logic cs, logic [1:0] lp, logic [7:0] f,
                      logic [3:0] d, logic junk, logic ehr, logic ebk);
    logic old_flk, old_plk;
    wr_en   = 1'b1;
    wr_data = {8'h00, d, f, 2'b00, lp, 1'b0, cs, bks, plk, flk, lol, com};
    if (junk) wr_data = wr_data | 32'hFF00_0C80;
    old_flk = m_flk;
    old_plk = m_plk;
    m_com = com;
    m_lol = lol;
    if (!old_plk) begin m_lpm = lp; m_csrc = cs; end
    if (!old_flk) begin m_mf = f; m_pd = d; end
    if (!bks) m_bks = 1'b0;
    else if (limp_en) m_bks = 1'b1;
    if (!m_once) begin m_flk = flk; m_plk = plk; m_once = 1'b1; end
    step(tag, ehr, ebk, 0);
    wr_en   = 1'b0;
    wr_data = '0;
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    por_n = 0; wr_en = 0; wr_data = 0; limp_en = 0; pll_locked = 1;
    hrst_active = 0; pmode = 0;
    model_clear();
    @(negedge clk);
    por();

    // R1 reserved bits, R2 decode of every output mode
    wreg("R1 reserved bits", 2'd1, 0, 0, 0, 0, 1, 2'd2, 8'h5A, 4'd3, 1, 0, 0);
    wreg("R2 mode 10", 2'd2, 0, 0, 0, 0, 1, 2'd2, 8'h5A, 4'd3, 0, 0, 0);
    wreg("R2 mode 11", 2'd3, 0, 0, 0, 0, 1, 2'd2, 8'h5A, 4'd3, 0, 0, 0);
    wreg("R2 mode 00", 2'd0, 0, 0, 0, 0, 1, 2'd2, 8'h5A, 4'd3, 0, 0, 0);
    // R3 locks ignored after the first write
    wreg("R3 late lock write", 2'd0, 0, 1, 1, 0, 0, 2'd1, 8'h66, 4'd7, 0, 0, 0);

    // R12 new power-on reset re-arms; R3/R4 frequency lock
    por();
    wreg("R12 first write sets flk", 2'd0, 0, 1, 0, 0, 1, 2'd1, 8'h11, 4'd2, 0, 0, 0);
    wreg("R4 mf/pdiv frozen", 2'd1, 0, 0, 1, 0, 0, 2'd2, 8'h22, 4'd5, 0, 0, 0);

    // R5/R6/R7/R11 power lock
    por();
    wreg("R5 first write sets plk", 2'd0, 0, 0, 1, 0, 1, 2'd1, 8'h10, 4'd1, 0, 0, 0);
    wreg("R5 lpm/csrc frozen", 2'd0, 0, 0, 0, 0, 0, 2'd3, 8'h10, 4'd1, 0, 0, 0);
    wreg("R6 mf change", 2'd0, 0, 0, 0, 0, 1, 2'd1, 8'h20, 4'd1, 0, 1, 0);
    step("R11 pulse ends", 0, 0, 0);
    wreg("R6 no change", 2'd0, 0, 0, 0, 0, 1, 2'd1, 8'h20, 4'd1, 0, 0, 0);
    pmode = 3'd3;
    step("R7 mode violation", 1, 0, 0);
    step("R7 single pulse", 0, 0, 0);
    pmode = 3'd0;
    step("R7 back to normal", 0, 0, 0);
    pmode = 3'd2;
    step("R7 second violation", 1, 0, 0);
    pmode = 3'd0;
    step("R7 normal", 0, 0, 0);
    wreg("R11 tamper", 2'd0, 0, 0, 0, 0, 1, 2'd1, 8'h30, 4'd1, 0, 1, 0);
    pmode = 3'd5;
    step("R11 no back-to-back pulse", 0, 0, 0);
    step("R11 violation held", 0, 0, 0);
    pmode = 3'd0;
    step("R11 normal", 0, 0, 0);

    // R8 backup switch
    limp_en = 0;
    wreg("R8 no limp", 2'd0, 0, 0, 0, 1, 1, 2'd1, 8'h30, 4'd1, 0, 0, 0);
    limp_en = 1;
    wreg("R8 switch", 2'd0, 0, 0, 0, 1, 1, 2'd1, 8'h30, 4'd1, 0, 1, 1);
    step("R8 pulses end", 0, 0, 0);
    wreg("R8 already set", 2'd0, 0, 0, 0, 1, 1, 2'd1, 8'h30, 4'd1, 0, 0, 0);

    // R9 loss of lock during hard reset
    hrst_active = 1; pll_locked = 0;
    step("R9 loss of lock", 0, 1, 0);
    step("R9 single request", 0, 0, 0);
    pll_locked = 1;
    step("R9 relock", 0, 0, 0);
    hrst_active = 0;
    step("R9 idle", 0, 0, 0);

    // R10 switch disabled: hold hard reset
    wreg("R10 set disable", 2'd0, 1, 0, 0, 1, 1, 2'd1, 8'h30, 4'd1, 0, 0, 0);
    hrst_active = 1; pll_locked = 0;
    step("R10 hold", 0, 0, 1);
    step("R10 hold", 0, 0, 1);
    pll_locked = 1;
    step("R10 relock", 0, 0, 0);
    hrst_active = 0; pll_locked = 0;
    step("R10 outside reset", 0, 0, 0);
    pll_locked = 1;
    step("R10 idle", 0, 0, 0);

    wait (q.size() == 0);
    #10;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule